// File: doc/BRIEF.md
# Unary and Shift Group Unit

This unit executes two single-operand opcode groups in one cycle. In these groups the middle field of the operand-descriptor byte picks a sub-operation instead of a second register. Opcode 0xF7 gives bitwise inversion, two's-complement negation and an unsigned widening multiply against the accumulator. Opcode 0xD3 gives a left shift, a zero-fill right shift and a sign-fill right shift, each by a count taken from register 1. The unit holds the eight-entry 32-bit register file and the sign, zero and overflow flags. It updates them on the clock edge that ends an issue cycle.

The surrounding core issues an operation by raising `op_valid` with the opcode and descriptor byte. It preloads operands through a single write port when no operation issues. All registers and flags are visible on the outputs. An operation this unit cannot execute raises `err_o` for one cycle and changes no register and no flag.

Top module: `ugs_unit`

## Requirements
- R1: After reset all eight registers, the three flags and `err_o` read zero.
- R2: With `op_valid` low and `ld_en` high, register `ld_idx` takes `ld_data` on the next edge. When `op_valid` is high in the same cycle, the load is ignored.
- R3: Opcode 0xF7 with select 2 inverts every bit of the selected register. SF takes bit 31 of the result, ZF is set when the result is zero, and OF is cleared. For example, 0x0F0F00FF becomes 0xF0F0FF00.
- R4: Opcode 0xF7 with select 3 replaces the selected register with its two's-complement negation. SF and ZF follow the result and OF is cleared. For example, 1 becomes 0xFFFFFFFF.
- R5: Negating 0x80000000 leaves the register unchanged and sets SF=1, ZF=0 and OF=1.
- R6: Opcode 0xF7 with select 4 forms the unsigned 64-bit product of register 0 and the selected register. The low half goes to register 0 and the high half to register 2. OF is set exactly when the high half is nonzero, and SF and ZF keep their values.
- R7: Opcode 0xD3 shifts by bits [4:0] of register 1. A count of 0 changes no register and no flag.
- R8: Opcode 0xD3 with select 4 shifts left with zero fill. SF and ZF follow the result. When the count is 1, OF becomes original bit 31 XOR original bit 30; for any other count OF is unchanged.
- R9: Opcode 0xD3 with select 5 shifts right with zero fill. SF is cleared and ZF follows the result. When the count is 1, OF becomes original bit 31; for any other count OF is unchanged. For example, 0xFFFFFFFD by 1 gives 0x7FFFFFFE.
- R10: Opcode 0xD3 with select 7 shifts right with sign fill. SF and ZF follow the result. When the count is 1, OF is cleared; for any other count OF is unchanged. For example, 0xFFFFFFFD by 1 gives 0xFFFFFFFE.
- R11: An issued operation is rejected in three cases: the opcode is neither 0xF7 nor 0xD3, the descriptor's mode field is not 3, or the select is not one listed above. A rejected operation sets `err_o` for the following cycle and leaves all registers and flags unchanged. `err_o` is zero after every other cycle.
- R12: Descriptor bits [7:6] are the mode field, bits [5:3] the select and bits [2:0] the index of the operated register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Register preload strobe |
| ld_idx | input | 3 | Preload register index |
| ld_data | input | 32 | Preload value |
| op_valid | input | 1 | Issue an operation this cycle |
| opcode | input | 8 | Opcode byte (0xF7 or 0xD3) |
| modrm | input | 8 | Descriptor byte: mode, select, register index |
| reg_file_o | output | 256 | All registers, register i at bits [32i+31:32i] |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| of_o | output | 1 | Overflow flag |
| err_o | output | 1 | Previous issue was rejected |

## Verification
Every cycle, the assertions check four things: that a rejected issue or a zero shift count freezes registers and flags, that the minimum-value negation sets its fixed flag pattern, and that the multiply overflow flag agrees with the high result register. They also check that a zero-fill right shift clears SF and that a load lands in its register. Only the bench's scenarios show the computed values: inverted, negated, product and shifted words against an independent model. The scenarios also cover the count-of-one overflow rules of each shift, the persistence of OF at other counts, and a load dropped under a concurrent issue.

// File: rtl/ugs_pkg.sv
package ugs_pkg;

    localparam logic [7:0] OPC_UNARY = 8'hF7;
    localparam logic [7:0] OPC_SHIFT = 8'hD3;
    localparam logic [1:0] MODE_REG  = 2'b11;

    localparam logic [2:0] SEL_NOT = 3'd2;
    localparam logic [2:0] SEL_NEG = 3'd3;
    localparam logic [2:0] SEL_MUL = 3'd4;
    localparam logic [2:0] SEL_SHL = 3'd4;
    localparam logic [2:0] SEL_SHR = 3'd5;
    localparam logic [2:0] SEL_SAR = 3'd7;

    typedef enum logic [2:0] {
        K_NONE, K_NOT, K_NEG, K_MUL, K_SHL, K_SHR, K_SAR
    } kind_t;

    typedef struct packed {
        logic sf;
        logic zf;
        logic of;
    } flags_t;

endpackage

// File: rtl/ugs_unary.sv
module ugs_unary
    import ugs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  kind_t              kind,
    input  logic [DATA_W-1:0]  rm_val,
    input  logic [DATA_W-1:0]  acc_val,
    input  flags_t             flags_in,
    output logic               wr_rm,
    output logic [DATA_W-1:0]  rm_res,
    output logic               wr_wide,
    output logic [DATA_W-1:0]  lo_res,
    output logic [DATA_W-1:0]  hi_res,
    output flags_t             flags_out
);
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [2*DATA_W-1:0] product;
    logic [DATA_W-1:0]   inv_v;
    logic [DATA_W-1:0]   neg_v;

    assign product = {{DATA_W{1'b0}}, acc_val} * {{DATA_W{1'b0}}, rm_val};
    assign inv_v   = ~rm_val;
    assign neg_v   = (~rm_val) + {{(DATA_W-1){1'b0}}, 1'b1};

    always_comb begin
        wr_rm     = 1'b0;
        rm_res    = rm_val;
        wr_wide   = 1'b0;
        lo_res    = product[DATA_W-1:0];
        hi_res    = product[2*DATA_W-1:DATA_W];
        flags_out = flags_in;
        unique case (kind)
            K_NOT: begin
                wr_rm        = 1'b1;
                rm_res       = inv_v;
                flags_out.sf = inv_v[DATA_W-1];
                flags_out.zf = (inv_v == '0);
                flags_out.of = 1'b0;
            end
            K_NEG: begin
                if (rm_val == MIN_NEG) begin
                    flags_out.sf = 1'b1;
                    flags_out.zf = 1'b0;
                    flags_out.of = 1'b1;
                end else begin
                    wr_rm        = 1'b1;
                    rm_res       = neg_v;
                    flags_out.sf = neg_v[DATA_W-1];
                    flags_out.zf = (neg_v == '0);
                    flags_out.of = 1'b0;
                end
            end
            K_MUL: begin
                wr_wide      = 1'b1;
                flags_out.of = (product[2*DATA_W-1:DATA_W] != '0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ugs_shift.sv
module ugs_shift
    import ugs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  kind_t              kind,
    input  logic [DATA_W-1:0]  rm_val,
    input  logic [CNT_W-1:0]   cnt,
    input  flags_t             flags_in,
    output logic               wr_rm,
    output logic [DATA_W-1:0]  rm_res,
    output flags_t             flags_out
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] shl_v;
    logic [DATA_W-1:0] shr_v;
    logic [DATA_W-1:0] sar_v;
    logic              cnt_zero;
    logic              cnt_one;

    assign shl_v    = rm_val << cnt;
    assign shr_v    = rm_val >> cnt;
    assign sar_v    = DATA_W'($signed(rm_val) >>> cnt);
    assign cnt_zero = (cnt == '0);
    assign cnt_one  = (cnt == ONE);

    always_comb begin
        wr_rm     = 1'b0;
        rm_res    = rm_val;
        flags_out = flags_in;
        if (!cnt_zero) begin
            unique case (kind)
                K_SHL: begin
                    wr_rm        = 1'b1;
                    rm_res       = shl_v;
                    flags_out.sf = shl_v[DATA_W-1];
                    flags_out.zf = (shl_v == '0);
                    if (cnt_one) flags_out.of = rm_val[DATA_W-1] ^ rm_val[DATA_W-2];
                end
                K_SHR: begin
                    wr_rm        = 1'b1;
                    rm_res       = shr_v;
                    flags_out.sf = 1'b0;
                    flags_out.zf = (shr_v == '0);
                    if (cnt_one) flags_out.of = rm_val[DATA_W-1];
                end
                K_SAR: begin
                    wr_rm        = 1'b1;
                    rm_res       = sar_v;
                    flags_out.sf = sar_v[DATA_W-1];
                    flags_out.zf = (sar_v == '0);
                    if (cnt_one) flags_out.of = 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ugs_unit.sv
module ugs_unit
    import ugs_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NREGS   = 8,
    parameter int ACC_IDX = 0,
    parameter int CNT_IDX = 1,
    parameter int HI_IDX  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en,
    input  logic [$clog2(NREGS)-1:0]  ld_idx,
    input  logic [DATA_W-1:0]         ld_data,
    input  logic                      op_valid,
    input  logic [7:0]                opcode,
    input  logic [7:0]                modrm,
    output logic [NREGS*DATA_W-1:0]   reg_file_o,
    output logic                      sf_o,
    output logic                      zf_o,
    output logic                      of_o,
    output logic                      err_o
);
    localparam int IDX_W = $clog2(NREGS);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [NREGS-1:0][DATA_W-1:0] regs;
        flags_t                       flags;
        logic                         err;
    } state_t;

    state_t state_d, state_q;

    logic [1:0]        mode_f;
    logic [2:0]        sel_f;
    logic [IDX_W-1:0]  rm_idx;
    kind_t             kind;
    logic              is_shift;
    logic [DATA_W-1:0] rm_val;
    logic [CNT_W-1:0]  cnt;

    assign mode_f = modrm[7:6];
    assign sel_f  = modrm[5:3];
    assign rm_idx = IDX_W'(modrm[2:0]);
    assign rm_val = state_q.regs[rm_idx];
    assign cnt    = state_q.regs[CNT_IDX][CNT_W-1:0];

    always_comb begin
        kind = K_NONE;
        if (mode_f == MODE_REG) begin
            if (opcode == OPC_UNARY) begin
                unique case (sel_f)
                    SEL_NOT: kind = K_NOT;
                    SEL_NEG: kind = K_NEG;
                    SEL_MUL: kind = K_MUL;
                    default: kind = K_NONE;
                endcase
            end else if (opcode == OPC_SHIFT) begin
                unique case (sel_f)
                    SEL_SHL: kind = K_SHL;
                    SEL_SHR: kind = K_SHR;
                    SEL_SAR: kind = K_SAR;
                    default: kind = K_NONE;
                endcase
            end
        end
    end

    assign is_shift = (kind == K_SHL) || (kind == K_SHR) || (kind == K_SAR);

    logic              u_wr_rm, u_wr_wide;
    logic [DATA_W-1:0] u_rm_res, u_lo, u_hi;
    flags_t            u_flags;

    ugs_unary #(.DATA_W(DATA_W)) u_unary (
        .kind      (kind),
        .rm_val    (rm_val),
        .acc_val   (state_q.regs[ACC_IDX]),
        .flags_in  (state_q.flags),
        .wr_rm     (u_wr_rm),
        .rm_res    (u_rm_res),
        .wr_wide   (u_wr_wide),
        .lo_res    (u_lo),
        .hi_res    (u_hi),
        .flags_out (u_flags)
    );

    logic              s_wr_rm;
    logic [DATA_W-1:0] s_rm_res;
    flags_t            s_flags;

    ugs_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .kind      (kind),
        .rm_val    (rm_val),
        .cnt       (cnt),
        .flags_in  (state_q.flags),
        .wr_rm     (s_wr_rm),
        .rm_res    (s_rm_res),
        .flags_out (s_flags)
    );

    always_comb begin
        state_d     = state_q;
        state_d.err = 1'b0;
        if (op_valid) begin
            if (kind == K_NONE) begin
                state_d.err = 1'b1;
            end else if (is_shift) begin
                if (s_wr_rm) state_d.regs[rm_idx] = s_rm_res;
                state_d.flags = s_flags;
            end else begin
                if (u_wr_rm) state_d.regs[rm_idx] = u_rm_res;
                if (u_wr_wide) begin
                    state_d.regs[ACC_IDX] = u_lo;
                    state_d.regs[HI_IDX]  = u_hi;
                end
                state_d.flags = u_flags;
            end
        end else if (ld_en) begin
            state_d.regs[ld_idx] = ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign reg_file_o = state_q.regs;
    assign sf_o       = state_q.flags.sf;
    assign zf_o       = state_q.flags.zf;
    assign of_o       = state_q.flags.of;
    assign err_o      = state_q.err;

    // R2: a preload with no issue lands in its register
    a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && ld_en) |=> state_q.regs[$past(ld_idx)] == $past(ld_data));

    // R5: negating the most negative value keeps the register, fixed flags
    a_r5_neg_min: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && kind == K_NEG && rm_val == MIN_NEG)
        |=> (of_o && sf_o && !zf_o && $stable(reg_file_o)));

    // R6: multiply overflow agrees with the high result register
    a_r6_mul_of: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && kind == K_MUL) |=> (of_o == (state_q.regs[HI_IDX] != '0)));

    // R7: zero count leaves everything in place
    a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_shift && cnt == '0)
        |=> ($stable(reg_file_o) && $stable({sf_o, zf_o, of_o})));

    // R9: zero-fill right shift clears the sign flag
    a_r9_shr_sf: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && kind == K_SHR && cnt != '0) |=> !sf_o);

    // R11: a rejection changes no state and only follows an issue
    a_r11_err_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(reg_file_o) && $stable({sf_o, zf_o, of_o}) && $past(op_valid)));

endmodule

// File: tb/tb_ugs_unit.sv
`timescale 1ns/1ps
module tb_ugs_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_en = 1'b0;
    logic [2:0]   ld_idx = '0;
    logic [31:0]  ld_data = '0;
    logic         op_valid = 1'b0;
    logic [7:0]   opcode = '0;
    logic [7:0]   modrm = '0;
    logic [255:0] reg_file_o;
    logic         sf_o, zf_o, of_o, err_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [31:0] m [8];
    bit msf, mzf, mof, merr;

    always #2.5 clk = ~clk;

    ugs_unit dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .op_valid(op_valid), .opcode(opcode), .modrm(modrm),
        .reg_file_o(reg_file_o), .sf_o(sf_o), .zf_o(zf_o), .of_o(of_o), .err_o(err_o)
    );

    function automatic string tag_of(input logic [7:0] opc, input logic [7:0] mr);
        if (mr[7:6] != 2'b11) return "R11";
        if (opc == 8'hF7) begin
            case (mr[5:3])
                3'd2: return "R3";
                3'd3: return "R4";
                3'd4: return "R6";
                default: return "R11";
            endcase
        end
        if (opc == 8'hD3) begin
            case (mr[5:3])
                3'd4: return "R8";
                3'd5: return "R9";
                3'd7: return "R10";
                default: return "R11";
            endcase
        end
        return "R11";
    endfunction

    task automatic model_op(input logic [7:0] opc, input logic [7:0] mr);
        logic [2:0]  sel = mr[5:3];
        logic [2:0]  ri = mr[2:0];
        logic [31:0] a = m[ri];
        logic [4:0]  c = m[1][4:0];
        logic [31:0] r;
        logic [63:0] p;
        merr = 1'b1;
        if (mr[7:6] == 2'b11 && opc == 8'hF7) begin
            if (sel == 3'd2) begin
                merr = 0; r = ~a; m[ri] = r; msf = r[31]; mzf = (r == 0); mof = 0;
            end else if (sel == 3'd3) begin
                merr = 0;
                if (a == 32'h8000_0000) begin msf = 1; mzf = 0; mof = 1; end
                else begin r = 32'd0 - a; m[ri] = r; msf = r[31]; mzf = (r == 0); mof = 0; end
            end else if (sel == 3'd4) begin
                merr = 0; p = {32'd0, m[0]} * {32'd0, a};
                m[0] = p[31:0]; m[2] = p[63:32]; mof = (p[63:32] != 0);
            end
        end else if (mr[7:6] == 2'b11 && opc == 8'hD3 &&
                     (sel == 3'd4 || sel == 3'd5 || sel == 3'd7)) begin
            merr = 0;
            if (c != 0) begin
                if (sel == 3'd4) begin
                    r = a << c; msf = r[31];
                    if (c == 1) mof = a[31] ^ a[30];
                end else if (sel == 3'd5) begin
                    r = a >> c; msf = 0;
                    if (c == 1) mof = a[31];
                end else begin
                    r = 32'($signed(a) >>> c); msf = r[31];
                    if (c == 1) mof = 0;
                end
                m[ri] = r; mzf = (r == 0);
            end
        end
    endtask

    task automatic check_state(input string tag);
        bit bad = 0;
        n_checks++;
        for (int i = 0; i < 8; i++) begin
            if (reg_file_o[i*32 +: 32] !== m[i]) begin
                bad = 1;
                $display("FAIL %s: reg%0d actual=%h expected=%h", tag, i, reg_file_o[i*32 +: 32], m[i]);
            end
        end
        if ({sf_o, zf_o, of_o, err_o} !== {msf, mzf, mof, merr}) begin
            bad = 1;
            $display("FAIL %s: sf/zf/of/err actual=%b%b%b%b expected=%b%b%b%b",
                     tag, sf_o, zf_o, of_o, err_o, msf, mzf, mof, merr);
        end
        if (bad) n_errors++;
    endtask

    task automatic load(input logic [2:0] i, input logic [31:0] v);
        @(negedge clk);
        ld_en = 1; ld_idx = i; ld_data = v;
        @(negedge clk);
        ld_en = 0;
        m[i] = v; merr = 0;
    endtask

    task automatic run_op(input logic [7:0] opc, input logic [7:0] mr, input string tag);
        @(negedge clk);
        op_valid = 1; opcode = opc; modrm = mr;
        @(negedge clk);
        op_valid = 0;
        model_op(opc, mr);
        check_state(tag);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_errors++;
                $display("FAIL watchdog: actual=hung expected=finished");
                $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m[i] = 0;
        msf = 0; mzf = 0; mof = 0; merr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R1 reset");

        load(3'd3, 32'h0F0F00FF);
        check_state("R2 load");
        // R2: load concurrent with an issue is dropped
        @(negedge clk);
        ld_en = 1; ld_idx = 3'd5; ld_data = 32'hDEAD_BEEF;
        op_valid = 1; opcode = 8'hF7; modrm = {2'b11, 3'd2, 3'd3};
        @(negedge clk);
        ld_en = 0; op_valid = 0;
        model_op(8'hF7, {2'b11, 3'd2, 3'd3});
        check_state("R2 load-during-issue / R3 not");
        if (m[3] !== 32'hF0F0FF00) begin n_errors++; $display("FAIL R3: model actual=%h expected=f0f0ff00", m[3]); end

        load(3'd6, 32'h0000_0000);
        run_op(8'hF7, {2'b11, 3'd2, 3'd6}, "R12 rm select / R3 not of zero");
        load(3'd4, 32'd1);
        run_op(8'hF7, {2'b11, 3'd3, 3'd4}, "R4 negate 1");
        load(3'd4, 32'h8000_0000);
        run_op(8'hF7, {2'b11, 3'd3, 3'd4}, "R5 negate min");
        load(3'd0, 32'd4); load(3'd1, 32'd3);
        run_op(8'hF7, {2'b11, 3'd4, 3'd1}, "R6 multiply small");
        load(3'd0, 32'hFFFF_FFFF); load(3'd5, 32'hFFFF_FFFF);
        run_op(8'hF7, {2'b11, 3'd4, 3'd5}, "R6 multiply wide");

        load(3'd1, 32'd32);
        load(3'd3, 32'd13);
        run_op(8'hD3, {2'b11, 3'd4, 3'd3}, "R7 zero count");
        load(3'd1, 32'd1);
        run_op(8'hD3, {2'b11, 3'd4, 3'd3}, "R8 shift left 13 by 1");
        load(3'd3, 32'h4000_0001);
        run_op(8'hD3, {2'b11, 3'd4, 3'd3}, "R8 shift left overflow");
        load(3'd3, 32'hFFFF_FFFD);
        run_op(8'hD3, {2'b11, 3'd5, 3'd3}, "R9 logical right");
        load(3'd3, 32'hFFFF_FFFD);
        run_op(8'hD3, {2'b11, 3'd7, 3'd3}, "R10 arithmetic right");
        load(3'd1, 32'd3);
        run_op(8'hD3, {2'b11, 3'd7, 3'd3}, "R10 count 3 keeps OF");

        run_op(8'h01, {2'b11, 3'd2, 3'd3}, "R11 bad opcode");
        run_op(8'hF7, {2'b00, 3'd2, 3'd3}, "R11 indirect mode");
        run_op(8'hF7, {2'b11, 3'd0, 3'd3}, "R11 bad unary select");
        run_op(8'hD3, {2'b11, 3'd6, 3'd3}, "R11 bad shift select");

        for (int it = 0; it < 600; it++) begin
            int pick = $urandom_range(0, 99);
            if (pick < 25) begin
                logic [31:0] v;
                int sp = $urandom_range(0, 5);
                v = (sp == 0) ? 32'h8000_0000 : (sp == 1) ? 32'd0 : (sp == 2) ? 32'($urandom_range(0, 2)) : $urandom;
                load(3'($urandom_range(0, 7)), v);
                check_state("R2 random load");
            end else begin
                logic [7:0] opc;
                logic [7:0] mr;
                int g = $urandom_range(0, 19);
                opc = (g < 9) ? 8'hF7 : (g < 18) ? 8'hD3 : 8'($urandom);
                mr = {($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b11, 3'($urandom), 3'($urandom)};
                if (opc == 8'hF7 && $urandom_range(0, 3) != 0) mr[5:3] = 3'($urandom_range(2, 4));
                run_op(opc, mr, tag_of(opc, mr));
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule